// File: doc/BRIEF.md
# Interrupt Priority Masking Arbiter

This block decides, every cycle, whether a pending exception may interrupt the code that is running, and if so which one. It keeps a pending bit and an active bit for three kinds of source: the non-maskable interrupt, the fault exception and a parameterised set of external interrupts. Each external interrupt carries an 8-bit programmable priority. Three mask settings shape the choice. A global mask blocks everything except the non-maskable interrupt and the fault exception. A fault mask leaves only the non-maskable interrupt. A priority floor blocks external interrupts whose priority number is at or above the floor.

Priorities are compared as unsigned ranks. The non-maskable interrupt has rank 0 and the fault exception has rank 1. An external interrupt of priority p has rank p+2. The core reports the rank it is running at on `cur_rank`. A rank of 2^PRIO_W+2 (258 by default) means no handler is running. The winning request is offered on a valid/ready pair. When it is accepted, its pending bit is cleared and its active bit is set. A completion strobe later clears the active bit.

The offer is a live arbitration result and not a held transfer. `take_valid` and `take_num` are computed from the current state. They may change or drop while `take_ready` is low, so the consumer must act on the number it sees in the cycle it asserts `take_ready`. No back-pressure is applied to the set or completion strobes: they are always accepted.

Top module: `irq_preempt_arb`

## Requirements
- R1: After reset, all pending and active bits are 0, the global mask, the fault mask and the floor are 0, and `take_valid` is 0.
- R2: A set strobe for a source makes its pending bit (bit 0 NMI, bit 1 fault, bit 2+i external i on `pend_o`) 1 at the next edge, and the bit stays 1 until the request is accepted.
- R3: A request is offered only if its rank is strictly below `cur_rank`. An equal rank is not enough.
- R4: While the global mask is 1, only the NMI (number 2) and the fault (number 3) can be offered.
- R5: While the fault mask is 1, only the NMI can be offered.
- R6: With a nonzero floor F, an external interrupt of priority p is blocked when p >= F. A floor of 0 blocks nothing.
- R7: A pending, non-active NMI is offered whenever `cur_rank` is above 0, whatever the masks.
- R8: Among eligible requests the lowest rank wins. Ties go to the lowest exception number (NMI 2, fault 3, external i is 16+i).
- R9: When `take_valid` and `take_ready` are both 1, the offered source's pending bit is cleared and its active bit is set at that edge.
- R10: An active source is never offered, even if its priority is raised meanwhile. `done_valid` with its number clears the active bit, and the source becomes eligible again.
- R11: Mask writes (`cfg_sel` 0 global mask from `cfg_wdata[0]`, 1 fault mask from `cfg_wdata[0]`, 2 floor from all of `cfg_wdata`) take effect at the edge only when `priv` is 1. With `priv` 0 they are ignored.
- R12: While `take_ready` is low, the offer follows the current state. A better request arriving replaces the offered number in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_set | input | 1 | Set strobe for the non-maskable interrupt |
| flt_set | input | 1 | Set strobe for the fault exception |
| irq_set | input | NUM_IRQ | Set strobes for external interrupts |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority of each external interrupt, interrupt i at bits i*PRIO_W upward |
| cur_rank | input | PRIO_W+2 | Rank of the running code, 2^PRIO_W+2 when no handler runs |
| priv | input | 1 | Privileged access; mask writes need it |
| cfg_wr | input | 1 | Mask write strobe |
| cfg_sel | input | 2 | Mask selector: 0 global, 1 fault, 2 floor |
| cfg_wdata | input | PRIO_W | Mask write data |
| take_valid | output | 1 | An exception may preempt |
| take_ready | input | 1 | Core accepts the offered exception |
| take_num | output | clog2(NUM_IRQ+16) | Exception number offered |
| done_valid | input | 1 | Handler completion strobe |
| done_num | input | clog2(NUM_IRQ+16) | Exception number of the completed handler |
| pend_o | output | NUM_IRQ+2 | Pending bits per source |
| act_o | output | NUM_IRQ+2 | Active bits per source |
| mask_all_q | output | 1 | Global mask state |
| mask_flt_q | output | 1 | Fault mask state |
| floor_q | output | PRIO_W | Priority floor state |

## Verification
Acceptance of one exception and completion of another can land on the same edge. Both then update the active bits: one bit is set and another is cleared. The bench provokes this with external interrupt 0 active and interrupt 3 offered. In one cycle it asserts `take_ready` and a `done_valid` for number 16. It then checks that bit 5 of `act_o` is set, that bit 2 is clear, and that interrupt 0, pending again with a raised priority, is offered at once. A new set strobe arriving while an offer waits for acceptance is also exercised. The bench checks that the offered number follows the better request rather than holding the old one.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NMI_NUM  = 2;
  localparam int FLT_NUM  = 3;
  localparam int EXT_BASE = 16;

  typedef enum logic [1:0] {
    SEL_ALL   = 2'd0,
    SEL_FLT   = 2'd1,
    SEL_FLOOR = 2'd2
  } cfg_sel_e;

  // source index (0 NMI, 1 fault, 2.. external) to exception number
  function automatic int num_of_src(input int s);
    if (s == 0)      return NMI_NUM;
    else if (s == 1) return FLT_NUM;
    else             return s - 2 + EXT_BASE;
  endfunction
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [PRIO_W-1:0] cfg_wdata,
  output logic              mask_all,
  output logic              mask_flt,
  output logic [PRIO_W-1:0] floor_lvl
);
  import irq_arb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_all  <= 1'b0;
      mask_flt  <= 1'b0;
      floor_lvl <= '0;
    end else if (cfg_wr && priv) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_ALL:   mask_all  <= cfg_wdata[0];
        SEL_FLT:   mask_flt  <= cfg_wdata[0];
        SEL_FLOOR: floor_lvl <= cfg_wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int SRC   = 10,
  parameter int EXC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC-1:0]   set_vec,
  input  logic [SRC-1:0]   take_hot,
  input  logic             done_valid,
  input  logic [EXC_W-1:0] done_num,
  output logic [SRC-1:0]   pend,
  output logic [SRC-1:0]   act
);
  import irq_arb_pkg::*;

  logic [SRC-1:0] done_hot;

  for (genvar s = 0; s < SRC; s++) begin : g_done
    assign done_hot[s] = done_valid && (done_num == EXC_W'(num_of_src(s)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      pend <= (pend & ~take_hot) | set_vec;
      act  <= (act & ~done_hot) | take_hot;
    end
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 8,
  parameter int SRC     = NUM_IRQ + 2,
  parameter int RK_W    = PRIO_W + 2
) (
  input  logic [SRC-1:0]            pend,
  input  logic [SRC-1:0]            act,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  input  logic [RK_W-1:0]           cur_rank,
  input  logic                      mask_all,
  input  logic                      mask_flt,
  input  logic [PRIO_W-1:0]         floor_lvl,
  output logic [SRC-1:0]            elig,
  output logic [SRC*RK_W-1:0]       rank
);
  for (genvar s = 0; s < SRC; s++) begin : g_src
    logic [RK_W-1:0] rk;
    logic            ok;
    if (s == 0) begin : g_nmi
      assign rk = '0;
      assign ok = 1'b1;
    end else if (s == 1) begin : g_flt
      assign rk = RK_W'(1);
      assign ok = !mask_flt;
    end else begin : g_ext
      logic [PRIO_W-1:0] p;
      assign p  = prio[(s-2)*PRIO_W +: PRIO_W];
      assign rk = {2'b00, p} + RK_W'(2);
      assign ok = !mask_all && !mask_flt && !((floor_lvl != '0) && (p >= floor_lvl));
    end
    assign rank[s*RK_W +: RK_W] = rk;
    assign elig[s] = pend[s] && !act[s] && ok && (rk < cur_rank);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int SRC   = 10,
  parameter int RK_W  = 10,
  parameter int EXC_W = 5
) (
  input  logic [SRC-1:0]      elig,
  input  logic [SRC*RK_W-1:0] rank,
  output logic                win_valid,
  output logic [SRC-1:0]      win_hot,
  output logic [EXC_W-1:0]    win_num
);
  import irq_arb_pkg::*;

  logic [RK_W-1:0] best;
  int              sel;

  always_comb begin
    win_valid = 1'b0;
    best      = '1;
    sel       = 0;
    for (int s = 0; s < SRC; s++) begin
      // strict compare keeps the lowest index on a tie
      if (elig[s] && (!win_valid || rank[s*RK_W +: RK_W] < best)) begin
        win_valid = 1'b1;
        best      = rank[s*RK_W +: RK_W];
        sel       = s;
      end
    end
    win_hot = win_valid ? (SRC'(1) << sel) : '0;
    win_num = EXC_W'(num_of_src(sel));
  end
endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb #(
  parameter  int NUM_IRQ = 8,
  parameter  int PRIO_W  = 8,
  localparam int SRC     = NUM_IRQ + 2,
  localparam int RK_W    = PRIO_W + 2,
  localparam int EXC_W   = $clog2(NUM_IRQ + 16)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      nmi_set,
  input  logic                      flt_set,
  input  logic [NUM_IRQ-1:0]        irq_set,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [RK_W-1:0]           cur_rank,
  input  logic                      priv,
  input  logic                      cfg_wr,
  input  logic [1:0]                cfg_sel,
  input  logic [PRIO_W-1:0]         cfg_wdata,
  output logic                      take_valid,
  input  logic                      take_ready,
  output logic [EXC_W-1:0]          take_num,
  input  logic                      done_valid,
  input  logic [EXC_W-1:0]          done_num,
  output logic [SRC-1:0]            pend_o,
  output logic [SRC-1:0]            act_o,
  output logic                      mask_all_q,
  output logic                      mask_flt_q,
  output logic [PRIO_W-1:0]         floor_q
);
  logic [SRC-1:0]      elig;
  logic [SRC*RK_W-1:0] rank;
  logic [SRC-1:0]      win_hot;
  logic [SRC-1:0]      take_hot;

  irq_mask_regs #(.PRIO_W(PRIO_W)) u_masks (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mask_all(mask_all_q), .mask_flt(mask_flt_q), .floor_lvl(floor_q)
  );

  irq_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .SRC(SRC), .RK_W(RK_W)) u_gate (
    .pend(pend_o), .act(act_o), .prio(irq_prio), .cur_rank(cur_rank),
    .mask_all(mask_all_q), .mask_flt(mask_flt_q), .floor_lvl(floor_q),
    .elig(elig), .rank(rank)
  );

  irq_pick #(.SRC(SRC), .RK_W(RK_W), .EXC_W(EXC_W)) u_pick (
    .elig(elig), .rank(rank), .win_valid(take_valid),
    .win_hot(win_hot), .win_num(take_num)
  );

  assign take_hot = take_ready ? win_hot : '0;

  irq_src_state #(.SRC(SRC), .EXC_W(EXC_W)) u_state (
    .clk(clk), .rst_n(rst_n), .set_vec({irq_set, flt_set, nmi_set}),
    .take_hot(take_hot), .done_valid(done_valid), .done_num(done_num),
    .pend(pend_o), .act(act_o)
  );
endmodule

// File: rtl/irq_preempt_arb_chk.sv
module irq_preempt_arb_chk #(
  parameter  int NUM_IRQ = 8,
  parameter  int PRIO_W  = 8,
  localparam int SRC     = NUM_IRQ + 2,
  localparam int RK_W    = PRIO_W + 2,
  localparam int EXC_W   = $clog2(NUM_IRQ + 16)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_valid,
  input logic              take_ready,
  input logic [EXC_W-1:0]  take_num,
  input logic              cfg_wr,
  input logic              priv,
  input logic              mask_all_q,
  input logic              mask_flt_q,
  input logic [PRIO_W-1:0] floor_q,
  input logic [SRC-1:0]    pend_o,
  input logic [SRC-1:0]    act_o,
  input logic [RK_W-1:0]   cur_rank
);
  import irq_arb_pkg::*;

  localparam logic [EXC_W-1:0] N_NMI = EXC_W'(NMI_NUM);
  localparam logic [EXC_W-1:0] N_FLT = EXC_W'(FLT_NUM);

  logic [SRC-1:0] offer_mask;
  always_comb begin
    offer_mask = '0;
    for (int s = 0; s < SRC; s++)
      if (take_num == EXC_W'(num_of_src(s))) offer_mask[s] = 1'b1;
  end

  // R4
  allmask_only_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all_q && take_valid |-> (take_num == N_NMI) || (take_num == N_FLT));

  // R5
  fltmask_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_flt_q && take_valid |-> take_num == N_NMI);

  // R7
  nmi_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[0] && !act_o[0] && (cur_rank != '0) |-> take_valid && take_num == N_NMI);

  // R9
  take_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid && take_ready |=> (act_o & $past(offer_mask)) != '0);

  // R10
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (act_o & offer_mask) == '0);

  // R11
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !priv |=> $stable(mask_all_q) && $stable(mask_flt_q) && $stable(floor_q));
endmodule

bind irq_preempt_arb irq_preempt_arb_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_valid(take_valid), .take_ready(take_ready),
  .take_num(take_num), .cfg_wr(cfg_wr), .priv(priv), .mask_all_q(mask_all_q),
  .mask_flt_q(mask_flt_q), .floor_q(floor_q), .pend_o(pend_o), .act_o(act_o),
  .cur_rank(cur_rank)
);

// File: tb/irq_preempt_arb_test.sv
module irq_preempt_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam logic [9:0] IDLE = 10'd258;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_set = 0, flt_set = 0;
  logic [NI-1:0] irq_set = '0;
  logic [7:0] prio_b [NI];
  logic [NI*8-1:0] irq_prio;
  logic [9:0] cur_rank = IDLE;
  logic priv = 1, cfg_wr = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic take_valid, take_ready = 0;
  logic [4:0] take_num;
  logic done_valid = 0;
  logic [4:0] done_num = 0;
  logic [9:0] pend_o, act_o;
  logic mask_all_q, mask_flt_q;
  logic [7:0] floor_q;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NI; i++) irq_prio[i*8 +: 8] = prio_b[i];

  irq_preempt_arb uut (
    .clk(clk), .rst_n(rst_n), .nmi_set(nmi_set), .flt_set(flt_set),
    .irq_set(irq_set), .irq_prio(irq_prio), .cur_rank(cur_rank), .priv(priv),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .take_valid(take_valid), .take_ready(take_ready), .take_num(take_num),
    .done_valid(done_valid), .done_num(done_num), .pend_o(pend_o), .act_o(act_o),
    .mask_all_q(mask_all_q), .mask_flt_q(mask_flt_q), .floor_q(floor_q)
  );

  typedef struct packed {
    logic       all;
    logic       flt;
    logic [7:0] floor_v;
    logic [9:0] rank;
    logic [9:0] set;
    logic       val;
    logic [4:0] num;
    logic [3:0] req;
  } vec_t;

  // set bits: 0 NMI, 1 fault, 2+i external i; priorities 40 20 20 80 FF 10 60 00
  localparam vec_t TBL [15] = '{
    '{1'b0, 1'b0, 8'h00, IDLE,   10'h018, 1'b1, 5'd17, 4'd8}, // R8 tie
    '{1'b0, 1'b0, 8'h00, IDLE,   10'h024, 1'b1, 5'd16, 4'd8}, // R8 lower rank
    '{1'b1, 1'b0, 8'h00, IDLE,   10'h082, 1'b1, 5'd3,  4'd4}, // R4 fault passes
    '{1'b1, 1'b0, 8'h00, IDLE,   10'h080, 1'b0, 5'd0,  4'd4}, // R4 external blocked
    '{1'b0, 1'b1, 8'h00, IDLE,   10'h082, 1'b0, 5'd0,  4'd5}, // R5 fault blocked
    '{1'b0, 1'b1, 8'h00, IDLE,   10'h003, 1'b1, 5'd2,  4'd5}, // R5 NMI passes
    '{1'b0, 1'b0, 8'h20, IDLE,   10'h00C, 1'b0, 5'd0,  4'd6}, // R6 equal masked
    '{1'b0, 1'b0, 8'h21, IDLE,   10'h00C, 1'b1, 5'd17, 4'd6}, // R6 below floor
    '{1'b0, 1'b0, 8'h00, IDLE,   10'h280, 1'b1, 5'd23, 4'd8}, // R8 priority 0 wins
    '{1'b0, 1'b0, 8'h00, 10'h022, 10'h008, 1'b0, 5'd0, 4'd3}, // R3 equal rank
    '{1'b0, 1'b0, 8'h00, 10'h023, 10'h008, 1'b1, 5'd17, 4'd3}, // R3 one better
    '{1'b0, 1'b0, 8'h00, 10'd1,  10'h003, 1'b1, 5'd2,  4'd7}, // R7 over fault handler
    '{1'b0, 1'b0, 8'h00, 10'd0,  10'h001, 1'b0, 5'd0,  4'd7}, // R7 inside NMI
    '{1'b0, 1'b0, 8'h01, IDLE,   10'h240, 1'b1, 5'd23, 4'd6}, // R6 floor 1
    '{1'b1, 1'b1, 8'h01, IDLE,   10'h001, 1'b1, 5'd2,  4'd7}  // R7 all masks
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d, input logic p);
    cfg_sel = sel; cfg_wdata = d; priv = p; cfg_wr = 1;
    tick();
    cfg_wr = 0; priv = 1;
  endtask

  task automatic pulse(input logic [9:0] v);
    {irq_set, flt_set, nmi_set} = v;
    tick();
    {irq_set, flt_set, nmi_set} = '0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    prio_b = '{8'h40, 8'h20, 8'h20, 8'h80, 8'hFF, 8'h10, 8'h60, 8'h00};

    for (int k = 0; k < 15; k++) begin
      do_reset();
      cfg_write(2'd0, {7'd0, TBL[k].all}, 1'b1);
      cfg_write(2'd1, {7'd0, TBL[k].flt}, 1'b1);
      cfg_write(2'd2, TBL[k].floor_v, 1'b1);
      cur_rank = TBL[k].rank;
      pulse(TBL[k].set);
      check($sformatf("R%0d vector %0d valid", TBL[k].req, k), int'(take_valid), int'(TBL[k].val));
      if (TBL[k].val)
        check($sformatf("R%0d vector %0d number", TBL[k].req, k), int'(take_num), int'(TBL[k].num));
    end

    // R1 reset state
    cur_rank = IDLE;
    do_reset();
    check("R1 take_valid", int'(take_valid), 0);
    check("R1 pend", int'(pend_o), 0);
    check("R1 act", int'(act_o), 0);
    check("R1 masks", int'({mask_all_q, mask_flt_q, floor_q}), 0);

    // R11 user-level writes ignored
    cfg_write(2'd0, 8'h01, 1'b0);
    check("R11 user global mask", int'(mask_all_q), 0);
    cfg_write(2'd2, 8'h40, 1'b0);
    check("R11 user floor", int'(floor_q), 0);
    cfg_write(2'd0, 8'h01, 1'b1);
    check("R11 priv global mask", int'(mask_all_q), 1);
    cfg_write(2'd0, 8'h00, 1'b1);

    // R2 pending held while not accepted
    pulse(10'h004);
    tick();
    tick();
    check("R2 pending held", int'(pend_o[2]), 1);
    check("R2 offer", int'(take_num), 16);

    // R12 offer follows better request
    pulse(10'h020);
    check("R12 keep better", int'(take_num), 16);
    pulse(10'h001);
    check("R12 NMI replaces", int'(take_num), 2);

    // R9 accept NMI
    take_ready = 1;
    tick();
    take_ready = 0;
    check("R9 NMI active", int'(act_o[0]), 1);
    check("R9 NMI pend cleared", int'(pend_o[0]), 0);
    check("R10 next offer", int'(take_num), 16);

    // R9 accept external 0
    take_ready = 1;
    tick();
    take_ready = 0;
    check("R9 ext0 active", int'(act_o[2]), 1);
    check("R9 ext3 offered", int'(take_num), 19);

    // R10 active source not re-offered after priority raise
    prio_b[0] = 8'h00;
    pulse(10'h004);
    check("R10 no reentry", int'(take_num), 19);
    check("R10 ext0 pending", int'(pend_o[2]), 1);

    // accept ext3 and complete ext0 on one edge
    take_ready = 1; done_valid = 1; done_num = 5'd16;
    tick();
    take_ready = 0; done_valid = 0;
    check("R9 ext3 active", int'(act_o[5]), 1);
    check("R10 ext0 done", int'(act_o[2]), 0);
    check("R10 ext0 reoffered", int'(take_valid && take_num == 5'd16), 1);

    done_valid = 1; done_num = 5'd2;
    tick();
    done_valid = 0;
    check("R10 NMI done", int'(act_o[0]), 0);

    report();
  end
endmodule